// File: doc/BRIEF.md
# Supply Monitor Output-Enable Controller

This block watches the logic supply of a power driver through three comparator flags: supply too low, supply too high, and supply below the power-on-reset level. Each fault flag passes through its own glitch filter. Entering a fault takes a short confirm delay, and leaving it takes a longer one. While any confirmed fault is present, the block turns the output stage off and pulls a shared active-low enable line to ground. Other devices on the board may also pull that line low, and the block senses its level and turns the outputs off when it is low.

An overvoltage fault can be made sticky with a configuration bit, but only in serial-interface mode. The sticky state is released by clearing the bit or by a power-on reset. A power-on-reset flag acts at once, bypassing every filter. When the flag clears, the block waits a fixed startup delay before it resumes operation, with all internal state at its default. In status-flag mode, supervision continues, but the latch and the threshold self-test inputs have no effect, and the detailed status bits read zero. Every pin of the block is a plain level or pulse, so there is no streaming interface and no back-pressure.

Top module: `supply_guard`

## Requirements
- R1: A filtered undervoltage is declared after the raw flag `uv_cmp_i` has been high for `OFF_CYC` consecutive clocks. A shorter pulse restarts the count. Once undervoltage is declared, `en_line_pull_o`=1 and `stage_en_o`=0.
- R2: A declared undervoltage or overvoltage clears only after its raw flag has been low for `ON_CYC` consecutive clocks.
- R3: A filtered overvoltage is declared after the raw flag `ov_cmp_i` has been high for `OFF_CYC` consecutive clocks. While it is declared, `en_line_pull_o`=1 and `stage_en_o`=0.
- R4: With `sif_mode_i`=1 and `ov_latch_cfg_i`=1, a declared overvoltage becomes sticky. It keeps `en_line_pull_o`=1 after the supply recovers. It is released by `ov_latch_cfg_i`=0 or by a power-on reset.
- R5: With `sif_mode_i`=0, the overvoltage latch is disabled and the self-test inputs `uv_test_i`/`ov_test_i` are ignored. Filtering of the real comparator flags continues.
- R6: While `por_cmp_i`=1, `stage_en_o`=0 and `en_line_pull_o`=1 in the same cycle, with no filter delay.
- R7: After `por_cmp_i` falls, `op_ready_o` rises once `POR_CYC` clocks have passed with the flag low. Until then, the filters, the latch and the stage state are held at their default (cleared) values.
- R8: `stage_en_o` rises only one clock after a clock edge where the permit, `drive_req_i` and `en_line_i` were all high and both raw fault flags (including the self-test inputs in serial mode) were low. Dropping the request or the permit turns the stage off in the same cycle.
- R9: `en_line_i`=0 forces `stage_en_o`=0. A declared fault forces `stage_en_o`=0 even when `en_line_i` is held at 1.
- R10: `diag_hold_o`=1 exactly while undervoltage is declared. This tells the diagnostic store to freeze its contents.
- R11: When a declared undervoltage clears, `reprog_req_o` is high for exactly one cycle.
- R12: With `sif_mode_i`=1, `uv_stat_o` reports the declared undervoltage and `ov_stat_o` reports the declared overvoltage or the latched overvoltage. With `sif_mode_i`=0, both bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_cmp_i | input | 1 | Raw undervoltage comparator flag |
| ov_cmp_i | input | 1 | Raw overvoltage comparator flag |
| por_cmp_i | input | 1 | Supply below power-on-reset level |
| sif_mode_i | input | 1 | 1 = serial-interface mode, 0 = status-flag mode |
| ov_latch_cfg_i | input | 1 | Configuration bit that makes overvoltage sticky |
| uv_test_i | input | 1 | Undervoltage threshold self-test (serial mode only) |
| ov_test_i | input | 1 | Overvoltage threshold self-test (serial mode only) |
| drive_req_i | input | 1 | Request to enable the output stage |
| en_line_i | input | 1 | Sensed level of the shared enable line |
| en_line_pull_o | output | 1 | 1 = pull the shared enable line low |
| stage_en_o | output | 1 | Output-stage enable |
| uv_stat_o | output | 1 | Undervoltage status bit |
| ov_stat_o | output | 1 | Overvoltage status bit |
| diag_hold_o | output | 1 | Freeze diagnostic register updates |
| reprog_req_o | output | 1 | One-cycle pulse that asks software to reload the output configuration |
| op_ready_o | output | 1 | Startup delay complete |

## Verification
On every cycle, the assertions check the following:
- the immediate shutdown on power-on reset;
- the forced off state when the line is low;
- the raw-flag condition on every stage turn-on;
- the single-cycle reprogram pulse;
- the rule that the latch is released only by its bit, the mode or a reset;
- the zero status bits in status-flag mode;
- the filter counter bound.

The exact filter lengths can only be shown by the bench scenarios, which compare every output against the reference model on every clock. The scenarios cover glitches shorter than the confirm delay, the asymmetric recovery, the latch release paths, self-tests in each mode, and a power-on reset in the middle of operation.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;
  typedef enum logic [0:0] {
    CH_UV = 1'b0,
    CH_OV = 1'b1
  } fault_ch_e;

  localparam int unsigned NUM_CH = 2;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/sg_filter.sv
module sg_filter #(
  parameter int unsigned OFF_CYC = 16,
  parameter int unsigned ON_CYC  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic raw_i,
  output logic filt_o
);
  import supply_guard_pkg::*;

  localparam int unsigned MAXC = (OFF_CYC > ON_CYC) ? OFF_CYC : ON_CYC;
  localparam int unsigned CW   = cnt_width(MAXC);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYC - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;
  logic [CW-1:0] last;

  assign last = filt_q ? ON_LAST : OFF_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (srst) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == last) begin
      filt_q <= raw_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  // R1 R2 R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAXC));
endmodule

// File: rtl/sg_por_seq.sv
module sg_por_seq #(
  parameter int unsigned POR_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  output logic ready_o
);
  import supply_guard_pkg::*;

  localparam int unsigned CW = cnt_width(POR_CYC);
  localparam logic [CW-1:0] LAST = CW'(POR_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (por_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == LAST) rdy_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = rdy_q;

  // R7
  por_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> !rdy_q);
endmodule

// File: rtl/sg_fault_ctl.sv
module sg_fault_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic ready_i,
  input  logic por_i,
  input  logic uv_f_i,
  input  logic ov_f_i,
  input  logic uv_raw_i,
  input  logic ov_raw_i,
  input  logic latch_en_i,
  input  logic drive_req_i,
  input  logic en_line_i,
  output logic permit_o,
  output logic ov_hold_o,
  output logic stage_en_o,
  output logic reprog_o
);
  logic ov_lat_q;
  logic stage_q;
  logic uv_prev_q;
  logic stage_d;

  assign ov_hold_o = ov_f_i | ov_lat_q;
  assign permit_o  = ready_i & ~por_i & ~uv_f_i & ~ov_hold_o;

  // turn-on needs the raw flags clear; staying on does not
  assign stage_d = permit_o & drive_req_i & en_line_i &
                   (stage_q | (~uv_raw_i & ~ov_raw_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_lat_q  <= 1'b0;
      stage_q   <= 1'b0;
      uv_prev_q <= 1'b0;
    end else if (srst) begin
      ov_lat_q  <= 1'b0;
      stage_q   <= 1'b0;
      uv_prev_q <= 1'b0;
    end else begin
      ov_lat_q  <= latch_en_i & (ov_lat_q | ov_f_i);
      stage_q   <= stage_d;
      uv_prev_q <= uv_f_i;
    end
  end

  assign stage_en_o = stage_q & permit_o & drive_req_i & en_line_i;
  assign reprog_o   = uv_prev_q & ~uv_f_i;

  // R8
  stage_on_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_en_o) |-> $past(!uv_raw_i && !ov_raw_i));
  // R11
  reprog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reprog_o |=> !reprog_o);
  // R4
  latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ov_lat_q) |-> ($past(!latch_en_i) || $past(srst)));
  // R9
  line_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_line_i |-> !stage_en_o);
endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int unsigned OFF_CYC = 16,
  parameter int unsigned ON_CYC  = 32,
  parameter int unsigned POR_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_cmp_i,
  input  logic ov_cmp_i,
  input  logic por_cmp_i,
  input  logic sif_mode_i,
  input  logic ov_latch_cfg_i,
  input  logic uv_test_i,
  input  logic ov_test_i,
  input  logic drive_req_i,
  input  logic en_line_i,
  output logic en_line_pull_o,
  output logic stage_en_o,
  output logic uv_stat_o,
  output logic ov_stat_o,
  output logic diag_hold_o,
  output logic reprog_req_o,
  output logic op_ready_o
);
  import supply_guard_pkg::*;

  logic                ready;
  logic                srst;
  logic [NUM_CH-1:0]   raw;
  logic [NUM_CH-1:0]   filt;
  logic                permit;
  logic                ov_hold;
  logic                latch_en;

  sg_por_seq #(.POR_CYC(POR_CYC)) u_por (
    .clk(clk), .rst_n(rst_n), .por_i(por_cmp_i), .ready_o(ready)
  );

  assign srst = ~ready | por_cmp_i;

  // self-tests act only in serial-interface mode
  assign raw[CH_UV] = uv_cmp_i | (sif_mode_i & uv_test_i);
  assign raw[CH_OV] = ov_cmp_i | (sif_mode_i & ov_test_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_filt
    sg_filter #(.OFF_CYC(OFF_CYC), .ON_CYC(ON_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .srst(srst),
      .raw_i(raw[g]), .filt_o(filt[g])
    );
  end

  assign latch_en = sif_mode_i & ov_latch_cfg_i;

  sg_fault_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .srst(srst), .ready_i(ready),
    .por_i(por_cmp_i), .uv_f_i(filt[CH_UV]), .ov_f_i(filt[CH_OV]),
    .uv_raw_i(raw[CH_UV]), .ov_raw_i(raw[CH_OV]), .latch_en_i(latch_en),
    .drive_req_i(drive_req_i), .en_line_i(en_line_i),
    .permit_o(permit), .ov_hold_o(ov_hold),
    .stage_en_o(stage_en_o), .reprog_o(reprog_req_o)
  );

  assign en_line_pull_o = ~permit;
  assign uv_stat_o      = sif_mode_i & filt[CH_UV];
  assign ov_stat_o      = sif_mode_i & ov_hold;
  assign diag_hold_o    = filt[CH_UV];
  assign op_ready_o     = ready;

  // R6
  por_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_cmp_i |-> (!stage_en_o && en_line_pull_o));
  // R5 R12
  flag_mode_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sif_mode_i |-> (!uv_stat_o && !ov_stat_o));
  // R9
  fault_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_line_pull_o |-> !stage_en_o);
endmodule

// File: tb/tb_supply_guard.sv
module tb_supply_guard;
  localparam int CLK_PERIOD = 10;
  localparam int OFF = 4;
  localparam int ON  = 6;
  localparam int PORD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv = 0, ov = 0, por = 1, sif = 1, cfg = 0, uvt = 0, ovt = 0, drv = 1;
  logic ext_low = 0, short_hi = 0;
  logic line;
  logic pull, stage, uvs, ovs, diag, reprog, rdy;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = short_hi | (~pull & ~ext_low);

  supply_guard #(.OFF_CYC(OFF), .ON_CYC(ON), .POR_CYC(PORD)) dut (
    .clk(clk), .rst_n(rst_n), .uv_cmp_i(uv), .ov_cmp_i(ov), .por_cmp_i(por),
    .sif_mode_i(sif), .ov_latch_cfg_i(cfg), .uv_test_i(uvt), .ov_test_i(ovt),
    .drive_req_i(drv), .en_line_i(line), .en_line_pull_o(pull),
    .stage_en_o(stage), .uv_stat_o(uvs), .ov_stat_o(ovs), .diag_hold_o(diag),
    .reprog_req_o(reprog), .op_ready_o(rdy)
  );

  // behavioural reference state
  int m_rdy, m_pc, m_uf, m_uc, m_of, m_oc, m_lat, m_st, m_up;

  function automatic int permit_now();
    return (m_rdy != 0 && !por && m_uf == 0 && m_of == 0 && m_lat == 0) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy = 0; m_pc = 0; m_uf = 0; m_uc = 0; m_of = 0; m_oc = 0;
      m_lat = 0; m_st = 0; m_up = 0;
    end else begin
      int ru, ro, p, clr, n_st;
      ru = (uv || (sif && uvt)) ? 1 : 0;
      ro = (ov || (sif && ovt)) ? 1 : 0;
      p = permit_now();
      n_st = (p != 0 && drv && line && (m_st != 0 || (ru == 0 && ro == 0))) ? 1 : 0;
      clr = (m_rdy == 0 || por) ? 1 : 0;
      if (clr != 0) begin
        m_uf = 0; m_uc = 0; m_of = 0; m_oc = 0; m_lat = 0; m_st = 0; m_up = 0;
      end else begin
        m_lat = (sif && cfg && (m_lat != 0 || m_of != 0)) ? 1 : 0;
        m_st = n_st;
        m_up = m_uf;
        if (ru == m_uf) m_uc = 0;
        else if (m_uc == ((m_uf != 0) ? ON : OFF) - 1) begin m_uf = ru; m_uc = 0; end
        else m_uc++;
        if (ro == m_of) m_oc = 0;
        else if (m_oc == ((m_of != 0) ? ON : OFF) - 1) begin m_of = ro; m_oc = 0; end
        else m_oc++;
      end
      if (por) begin m_rdy = 0; m_pc = 0; end
      else if (m_rdy == 0) begin
        if (m_pc == PORD - 1) m_rdy = 1; else m_pc++;
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int p;
    p = permit_now();
    chk("R1 R3 R6 R8 R9 stage", stage, (m_st != 0 && p != 0 && drv && line));
    chk("R1 R2 R3 R4 R6 pull", pull, (p == 0));
    chk("R5 R12 uv_stat", uvs, (sif && m_uf != 0));
    chk("R4 R5 R12 ov_stat", ovs, (sif && (m_of != 0 || m_lat != 0)));
    chk("R10 diag", diag, (m_uf != 0));
    chk("R11 reprog", reprog, (m_up != 0 && m_uf == 0));
    chk("R7 ready", rdy, (m_rdy != 0));
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(2);
    chk("R6 reset stage", stage, 1'b0);
    chk("R6 reset pull", pull, 1'b1);
    por = 0;
    step(4);
    chk("R7 not yet ready", rdy, 1'b0);
    step(3);
    chk("R7 ready", rdy, 1'b1);
    step(3);
    chk("R8 stage on", stage, 1'b1);
    // R1 short glitch
    uv = 1; step(3); uv = 0; step(2);
    chk("R1 glitch ignored", stage, 1'b1);
    uv = 1; step(6);
    chk("R1 uv off", stage, 1'b0);
    chk("R10 diag hold", diag, 1'b1);
    uv = 0; step(3);
    chk("R2 still off", stage, 1'b0);
    step(8);
    chk("R2 recovered", stage, 1'b1);
    // R3 overvoltage, not sticky
    ov = 1; step(6);
    chk("R3 ov off", pull, 1'b1);
    ov = 0; step(10);
    chk("R3 ov recovered", stage, 1'b1);
    // R4 sticky overvoltage
    cfg = 1; ov = 1; step(6); ov = 0; step(20);
    chk("R4 latch holds", pull, 1'b1);
    chk("R4 ov_stat latched", ovs, 1'b1);
    cfg = 0; step(3);
    chk("R4 released by cfg", stage, 1'b1);
    // R5 flag mode
    sif = 0; cfg = 1; ov = 1; step(6);
    chk("R5 flag mode ov still filtered", stage, 1'b0);
    chk("R5 flag ov_stat zero", ovs, 1'b0);
    ov = 0; step(10);
    chk("R5 no latch in flag mode", stage, 1'b1);
    uvt = 1; step(10);
    chk("R5 self-test ignored", stage, 1'b1);
    sif = 1; cfg = 0; step(6);
    chk("R12 self-test serial uv_stat", uvs, 1'b1);
    uvt = 0; step(10);
    chk("R12 serial recovered", stage, 1'b1);
    // R9 external pull and shorted line
    ext_low = 1; step(1);
    chk("R9 line low off", stage, 1'b0);
    ext_low = 0; step(3);
    short_hi = 1; uv = 1; step(6);
    chk("R9 fault beats high line", stage, 1'b0);
    uv = 0; step(10); short_hi = 0; step(2);
    // R8 raw fault blocks turn-on
    drv = 0; step(2);
    chk("R8 request dropped", stage, 1'b0);
    drv = 1; uv = 1; step(1);
    chk("R8 blocked by raw", stage, 1'b0);
    uv = 0; step(2);
    chk("R8 on after raw clear", stage, 1'b1);
    // R6 por mid-operation
    por = 1; #1;
    chk("R6 immediate stage off", stage, 1'b0);
    chk("R6 immediate pull", pull, 1'b1);
    step(2); por = 0; step(8);
    chk("R7 restart", stage, 1'b1);
    // R4 latch cleared by por
    cfg = 1; ov = 1; step(6); ov = 0; step(10);
    chk("R4 latch before por", pull, 1'b1);
    por = 1; step(2); por = 0; step(8);
    chk("R4 released by por", stage, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule